// File: doc/BRIEF.md
# Clock-Stretching I2C Target Controller

This block is an I2C target (slave) that responds to one 7-bit address. Software sets that address through a register. When a START is followed by a matching address byte, the block acknowledges it and latches the direction bit. At the falling edge of the acknowledge clock it raises its interrupt and sets an "addressed" status flag. From then on it moves one byte at a time. It holds SCL low after every byte until software touches the data register in the way that fits the chosen direction. For reads from the bus this is a data-register read, which may be a dummy read. For writes to the bus it is a data-register write.

Software picks the direction with a control bit. In receive mode the block acknowledges each byte unless the acknowledge-disable bit is set. In transmit mode it records the master's ninth-bit answer, so software can see the NACK that ends a read. It then switches to receive mode and does a dummy read, which releases the clock so the master can send STOP. SDA and SCL are open-drain outputs: an `_oe` output high pulls the line low.

Register map (2-bit offset): 0 = control (bit0 transmit mode, bit1 acknowledge disable). 1 = status, read only (bit0 clock held / interrupt pending, bit1 addressed, bit2 latched R/W, bit3 received acknowledge, 1 = NACK). 2 = own address in bits 6:0. 3 = data (a read returns the last received byte; a write supplies the next byte to send).

Top module: `i2c_stretch_slave`

## Requirements
- R1: After reset scl_oe, sda_oe and irq are 0 and the status register reads 0x00.
- R2: When the address byte's upper seven bits equal the own-address register, the block pulls SDA low on the ninth clock. It latches bit 0 of the address byte into status bit2. Once the ninth clock falls it sets irq, status bit0 and status bit1 (addressed).
- R3: When the address does not match, the block gives no acknowledge and raises no interrupt. It ignores all later bytes until the next START.
- R4: While irq is set the block holds SCL low. In transmit mode (control bit0 = 1) only a data-register write releases it. In receive mode only a data-register read releases it. An access of the other kind leaves the clock held.
- R5: Any write to the control register clears the addressed flag. The interrupt after a data byte reports it as 0.
- R6: In receive mode a byte arrives MSB first and is readable at offset 3. The block pulls SDA low on the ninth clock unless control bit1 is 1, in which case SDA stays released.
- R7: In transmit mode the written byte goes out MSB first. Status bit3 holds the SDA level the master drove on the ninth clock.
- R8: After a NACK, a control write selecting receive mode followed by a dummy data read releases SCL. A following STOP leaves the block idle with irq at 0.
- R9: A START or STOP in the middle of a byte aborts it. After a STOP the block waits for an address with SCL and SDA released. After a START the next byte is taken as an address.
- R10: The block only starts pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on data offset) |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Interrupt, set while a byte waits for service |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The hardest situation to reach is a master that wants to raise SCL while the block is stretching it. The bench gets there by driving its own SCL high during a hold and confirming that the wired-AND line stays low. It then lowers its SCL again before the releasing access, so that no false START or STOP can occur. Aborts need a START or STOP placed after a few bits of a byte, so the bench builds frames bit by bit rather than only in whole bytes. Randomised transactions vary the own address, hit/miss addresses, direction and length.

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);

  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_OWN = 2'd2, A_DATA = 2'd3;
  localparam logic [3:0] LAST_BIT = 4'd8, ACK_BIT = 4'd9;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_XFER, ST_HOLD} st_t;

  st_t        st;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic [3:0] cnt;
  logic [7:0] sh, rxd;
  logic [6:0] own;
  logic       tx, ack_off, xmit, aas, srw, rxak;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic ctrl_wr, data_wr, data_rd, release_ok;

  assign scl_s      = scl_sy[1];
  assign sda_s      = sda_sy[1];
  assign scl_rise   = scl_s & ~scl_q;
  assign scl_fall   = ~scl_s & scl_q;
  assign start_ev   = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev    = scl_s & scl_q & ~sda_q & sda_s;
  assign ctrl_wr    = reg_wr && reg_addr == A_CTRL;
  assign data_wr    = reg_wr && reg_addr == A_DATA;
  assign data_rd    = reg_rd && reg_addr == A_DATA;
  assign release_ok = (st == ST_HOLD) && (tx ? data_wr : data_rd);

  assign scl_oe = (st == ST_HOLD);
  assign irq    = scl_oe;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {6'd0, ack_off, tx};
      A_STAT:  reg_rdata = {4'd0, rxak, srw, aas, irq};
      A_OWN:   reg_rdata = {1'b0, own};
      default: reg_rdata = rxd;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      cnt <= '0;
      sh <= '0;
      rxd <= '0;
      own <= '0;
      tx <= 1'b0;
      ack_off <= 1'b0;
      xmit <= 1'b0;
      aas <= 1'b0;
      srw <= 1'b0;
      rxak <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        tx      <= reg_wdata[0];
        ack_off <= reg_wdata[1];
      end
      if (reg_wr && reg_addr == A_OWN) own <= reg_wdata[6:0];

      if (stop_ev) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
        aas    <= 1'b0;
      end else if (start_ev) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        aas    <= 1'b0;
      end else begin
        case (st)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise && cnt < LAST_BIT) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == LAST_BIT) begin
              if (sh[7:1] == own) begin
                sda_oe <= 1'b1;
                srw    <= sh[0];
                cnt    <= ACK_BIT;
              end else begin
                st <= ST_IDLE;
              end
            end else if (scl_fall && cnt == ACK_BIT) begin
              sda_oe <= 1'b0;
              aas    <= 1'b1;
              st     <= ST_HOLD;
            end
          end
          ST_XFER: begin
            if (!xmit) begin
              if (scl_rise && cnt < LAST_BIT) begin
                sh  <= {sh[6:0], sda_s};
                cnt <= cnt + 4'd1;
              end else if (scl_fall && cnt == LAST_BIT) begin
                rxd    <= sh;
                sda_oe <= ~ack_off;
                cnt    <= ACK_BIT;
              end else if (scl_fall && cnt == ACK_BIT) begin
                sda_oe <= 1'b0;
                aas    <= 1'b0;
                st     <= ST_HOLD;
              end
            end else begin
              if (scl_rise && cnt < LAST_BIT) begin
                cnt <= cnt + 4'd1;
              end else if (scl_rise && cnt == LAST_BIT) begin
                rxak <= sda_s;
                cnt  <= ACK_BIT;
              end else if (scl_fall && cnt < LAST_BIT) begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end else if (scl_fall && cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
              end else if (scl_fall && cnt == ACK_BIT) begin
                aas <= 1'b0;
                st  <= ST_HOLD;
              end
            end
          end
          ST_HOLD: begin
            if (release_ok) begin
              st   <= ST_XFER;
              cnt  <= '0;
              xmit <= tx;
              if (tx) begin
                sh     <= reg_wdata;
                sda_oe <= ~reg_wdata[7];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
        endcase
      end

      if (ctrl_wr) aas <= 1'b0;
    end
  end

  assert_irq_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aas) |-> irq);

  assert_release_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> ($past(reg_wr && reg_addr == A_DATA && tx) ||
                       $past(reg_rd && reg_addr == A_DATA && !tx)));

  assert_ctrl_clears_aas_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr && reg_addr == A_CTRL) |-> !aas);

  assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_ev) |-> (!scl_oe && !sda_oe));

  assert_sda_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

endmodule

// File: tb/i2c_stretch_slave_tb.sv
`timescale 1ns/1ps
module i2c_stretch_slave_tb;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl, sda;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign scl = m_scl & ~scl_oe;
  assign sda = m_sda & ~sda_oe;

  i2c_stretch_slave u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .scl_i(scl), .sda_i(sda), .scl_oe(scl_oe), .sda_oe(sda_oe));

  function automatic logic exp_ack(input logic [6:0] own_a, input logic [6:0] sent);
    return (own_a == sent) ? 1'b0 : 1'b1;
  endfunction

  function automatic logic [7:0] exp_stat(input logic hold, input logic ad,
                                           input logic rw, input logic nak);
    return {4'd0, nak, rw, ad, hold};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rrd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic mbit(input logic b, output logic r);
    m_sda = b; wq(Q);
    m_scl = 1'b1;
    while (scl !== 1'b1) @(negedge clk);
    wq(Q); r = sda;
    wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic mstart();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1;
    while (scl !== 1'b1) @(negedge clk);
    wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic mstop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1;
    while (scl !== 1'b1) @(negedge clk);
    wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic mwr(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) mbit(d[i], r);
    mbit(1'b1, ack);
  endtask

  task automatic mrd(input logic ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin mbit(1'b1, r); d[i] = r; end
    mbit(ack, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack, r;
    logic [7:0] d, s;
    logic [31:0] seed_sink;
    seed_sink = $urandom(32'd2024);
    wq(3); rst_n = 1'b1; wq(2);

    // R1 reset state
    check("R1 scl_oe", scl_oe, 0);
    check("R1 sda_oe", sda_oe, 0);
    check("R1 irq", irq, 0);
    rrd(2'd1, s); check("R1 status", s, 8'h00);

    // R2 match, receive direction
    rwr(2'd2, 8'h3A); rwr(2'd0, 8'h00);
    mstart(); mwr({7'h3A, 1'b0}, ack);
    check("R2 address ack", ack, exp_ack(7'h3A, 7'h3A));
    check("R2 irq", irq, 1);
    rrd(2'd1, s); check("R2 status", s, exp_stat(1, 1, 0, 0));
    // R4 wrong-kind access keeps the hold
    rwr(2'd3, 8'h55); wq(3);
    check("R4 write in rx keeps hold", scl_oe, 1);
    // R5 control write clears addressed flag
    rwr(2'd0, 8'h00);
    rrd(2'd1, s); check("R5 aas cleared", s, exp_stat(1, 0, 0, 0));
    // R4 master cannot raise SCL while held
    m_scl = 1'b1; wq(20);
    check("R4 line held low", scl, 0);
    m_scl = 1'b0; wq(2);
    rrd(2'd3, d); wq(2);
    check("R4 read releases", scl_oe, 0);
    // R6 receive byte with ack
    mwr(8'hA5, ack);
    check("R6 data ack", ack, 0);
    rrd(2'd1, s); check("R5 data irq aas=0", s, exp_stat(1, 0, 0, 0));
    rrd(2'd3, d); check("R6 received byte", d, 8'hA5);
    // R6 acknowledge disabled
    rwr(2'd0, 8'h02);
    mwr(8'h5C, ack);
    check("R6 ack disabled", ack, 1);
    rrd(2'd3, d); check("R6 received byte 2", d, 8'h5C);
    mstop(); wq(2);
    check("R8 idle after stop", irq, 0);

    // R3 mismatch
    rwr(2'd0, 8'h00);
    mstart(); mwr({7'h20, 1'b0}, ack);
    check("R3 no ack", ack, exp_ack(7'h3A, 7'h20));
    check("R3 no irq", irq, 0);
    mwr({7'h3A, 1'b0}, ack);
    check("R3 later byte ignored", ack, 1);
    check("R3 still no irq", irq, 0);
    mstop();

    // R7 transmit
    rwr(2'd0, 8'h01);
    mstart(); mwr({7'h3A, 1'b1}, ack);
    check("R2 read address ack", ack, 0);
    rrd(2'd1, s); check("R2 srw latched", s, exp_stat(1, 1, 1, 0));
    rrd(2'd3, d); wq(3);
    check("R4 read in tx keeps hold", scl_oe, 1);
    rwr(2'd3, 8'hC3);
    mrd(1'b0, d); check("R7 sent byte", d, 8'hC3);
    rrd(2'd1, s); check("R7 rxak ack", s, exp_stat(1, 0, 1, 0));
    rwr(2'd3, 8'h96);
    mrd(1'b1, d); check("R7 sent byte 2", d, 8'h96);
    rrd(2'd1, s); check("R7 rxak nack", s, exp_stat(1, 0, 1, 1));
    // R8 NACK turnaround
    rwr(2'd0, 8'h00);
    check("R8 ctrl write alone keeps hold", scl_oe, 1);
    rrd(2'd3, d); wq(2);
    check("R8 dummy read releases", scl_oe, 0);
    mstop(); wq(2);
    check("R8 idle irq", irq, 0);
    check("R8 idle sda", sda_oe, 0);

    // R9 STOP mid-byte
    mstart(); mwr({7'h3A, 1'b0}, ack);
    rrd(2'd3, d);
    for (int i = 0; i < 4; i++) mbit(i[0], r);
    mstop(); wq(2);
    rrd(2'd1, s);
    check("R9 stop abort hold/aas", {30'd0, s[1:0]}, 0);
    check("R9 stop abort scl", scl_oe, 0);
    // R9 START mid-byte
    mstart(); mwr({7'h3A, 1'b0}, ack);
    rrd(2'd3, d);
    for (int i = 0; i < 3; i++) mbit(1'b1, r);
    mstart(); mwr({7'h3A, 1'b0}, ack);
    check("R9 restart address ack", ack, 0);
    check("R9 restart irq", irq, 1);
    rrd(2'd3, d);
    mstop();

    // randomised transactions (R2 R3 R6 R7)
    for (int it = 0; it < 8; it++) begin
      logic [6:0] o, a;
      logic dir;
      int n;
      o = 7'($urandom % 128);
      a = ($urandom % 2 == 0) ? o : (o ^ 7'(1 + $urandom % 127));
      dir = 1'($urandom % 2);
      n = 1 + int'($urandom % 3);
      rwr(2'd2, {1'b0, o});
      rwr(2'd0, {7'd0, dir});
      mstart(); mwr({a, dir}, ack);
      check("R2/R3 random address ack", ack, exp_ack(o, a));
      if (o == a) begin
        if (!dir) begin
          rrd(2'd3, d);
          for (int k = 0; k < n; k++) begin
            logic [7:0] v;
            v = 8'($urandom);
            mwr(v, ack);
            check("R6 random ack", ack, 0);
            rrd(2'd3, d);
            check("R6 random data", d, v);
          end
        end else begin
          for (int k = 0; k < n; k++) begin
            logic [7:0] v;
            v = 8'($urandom);
            rwr(2'd3, v);
            mrd((k == n - 1), d);
            check("R7 random data", d, v);
            rrd(2'd1, s);
            check("R7 random rxak", s[3], (k == n - 1));
          end
          rwr(2'd0, 8'h00);
          rrd(2'd3, d);
        end
      end else begin
        mwr(8'($urandom), ack);
        check("R3 random ignored", ack, 1);
      end
      mstop(); wq(2);
      check("R8 random end idle", scl_oe, 0);
    end

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule